// File: doc/BRIEF.md
# Asynchronous Memory Read Engine with Ready-Extended Strobes

This block moves a run of 32-bit words from an asynchronous external memory into an on-chip sink. A request names a base word address and a word count. For each word the engine drives the address, holds the memory-select, output-enable and read-enable strobes (all active low) through a programmable access window, and captures the data bus. The captured word is then offered on a valid/ready sink port. When ready extension is on, the external device can stretch every access by holding its ready line low. This lets a slow source, such as a latch fed by an image sensor, pace the transfer.

Reads are grouped into bursts of eight. After each full burst that is not the last, the engine idles for a fixed gap with the strobes released. After the final word of a request, the engine idles for a reload gap before it takes the next request. This models the time a descriptor-driven controller needs between transfers.

On the request port, a request is taken on a clock edge where `req_valid` and `req_ready` are both high. On the sink port, a word leaves on an edge where `snk_valid` and `snk_ready` are both high. While the sink holds back, `snk_data` stays fixed and no new read starts. The timing inputs are sampled when a request is taken.

Top module: `amem_read_master`

## Requirements
- R1: After reset, `mem_sel_n`, `mem_oe_n` and `mem_re_n` are 1, `busy` and `snk_valid` are 0, and `req_ready` is 1.
- R2: Each read opens with a setup phase of `cfg_setup` cycles, with a value of 0 treated as 1. In this phase the address is driven and all three strobes are 1. Then `mem_sel_n`, `mem_oe_n` and `mem_re_n` fall to 0 in the same cycle, for an access phase of `cfg_access` cycles, with 0 treated as 1.
- R3: With `cfg_ready_en`=0, `mem_re_n` returns to 1 right after the access phase. In that one capture cycle, `mem_sel_n` and `mem_oe_n` stay 0, and `mem_data` is sampled at the clock edge that ends the cycle.
- R4: With `cfg_ready_en`=1, `mem_ready` is sampled at each edge from the last access cycle onward. `mem_re_n` stays 0 until an edge that samples `mem_ready`=1, and the capture cycle follows that edge.
- R5: After capture, all strobes are 1 for a hold phase of `cfg_hold` cycles, with 0 treated as 1.
- R6: After every eighth read of a request, when words remain, all strobes stay 1 for GAP_CYCLES cycles (9 by default) before the next setup.
- R7: After the final word, the engine waits RELOAD_CYCLES cycles with `req_ready`=0 before it accepts another request.
- R8: A word offered on the sink stays stable until it is accepted. The hold phase does not end while a word is pending and not being accepted.
- R9: `busy` is 1 from the cycle after a non-zero request is taken until the last word has been accepted. While `busy` is 0, no strobe is asserted.
- R10: A request with a count of 0 is taken, and no strobe is asserted, `busy` stays 0 and `req_ready` stays 1.
- R11: A count above MAX_WORDS is treated as MAX_WORDS.
- R12: Word k of a request is read from address base+k, and the words reach the sink in that order with the data that was on `mem_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | AW | Base word address |
| req_count | input | CW | Number of words |
| cfg_setup | input | TW | Setup cycles (0 treated as 1) |
| cfg_access | input | TW | Access cycles (0 treated as 1) |
| cfg_hold | input | TW | Hold cycles (0 treated as 1) |
| cfg_ready_en | input | 1 | Stretch access until ready is sampled high |
| mem_addr | output | AW | External word address |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read enable, active low |
| mem_ready | input | 1 | External ready |
| mem_data | input | DW | External read data |
| snk_valid | output | 1 | Sink word valid |
| snk_ready | input | 1 | Sink accepts word |
| snk_data | output | DW | Sink word |
| busy | output | 1 | Transfer in progress |

## Verification
Two things can happen in the same cycle. The sink can accept the previous word in the same cycle that the hold phase reaches its last count, and that decides whether the next setup starts at once or stalls. Separately, the ready line can be high on the very last access cycle, so the access is not stretched at all. The bench drives `snk_ready` and `mem_ready` from independent pseudo-random streams, so both of these coincidences occur many times across long transfers. A cycle-accurate reference then judges every strobe, address, sink and status output against the timing rules.

// File: rtl/amrm_pkg.sv
package amrm_pkg;
  localparam int TW = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_CAPT,
    ST_HOLD,
    ST_GAP,
    ST_RELOAD
  } rd_state_e;

  typedef struct packed {
    logic [TW-1:0] setup;
    logic [TW-1:0] access;
    logic [TW-1:0] hold;
    logic          ready_en;
  } rd_timing_t;
endpackage

// File: rtl/amrm_phase_timer.sv
module amrm_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/amrm_word_tracker.sv
module amrm_word_tracker #(
  parameter int AW        = 32,
  parameter int MAX_WORDS = 65536,
  parameter int BURST_LEN = 8,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  logic          step,
  input  logic          burst_clr,
  output logic [AW-1:0] addr,
  output logic          none_left,
  output logic          burst_full
);
  localparam int PW = $clog2(BURST_LEN + 1);

  logic [CW-1:0] remain;
  logic [PW-1:0] pos;
  logic [CW-1:0] clamped;

  assign clamped = (count > CW'(MAX_WORDS)) ? CW'(MAX_WORDS) : count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
      pos    <= '0;
    end else if (start) begin
      addr   <= base;
      remain <= clamped;
      pos    <= '0;
    end else begin
      if (step) begin
        addr   <= addr + 1'b1;
        remain <= remain - 1'b1;
        pos    <= pos + 1'b1;
      end else if (burst_clr) begin
        pos <= '0;
      end
    end
  end

  assign none_left  = (remain == '0);
  assign burst_full = (pos == PW'(BURST_LEN));

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= PW'(BURST_LEN)); // R6
  AST_STEP_NEEDS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !none_left); // R11
endmodule

// File: rtl/amrm_sink_reg.sv
module amrm_sink_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [DW-1:0] snk_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snk_valid <= 1'b0;
      snk_data  <= '0;
    end else if (load) begin
      snk_valid <= 1'b1;
      snk_data  <= din;
    end else if (snk_ready) begin
      snk_valid <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!snk_valid || snk_ready)); // R8
  AST_SINK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data))); // R8
endmodule

// File: rtl/amem_read_master.sv
module amem_read_master
  import amrm_pkg::*;
#(
  parameter int AW            = 32,
  parameter int DW            = 32,
  parameter int MAX_WORDS     = 65536,
  parameter int BURST_LEN     = 8,
  parameter int GAP_CYCLES    = 9,
  parameter int RELOAD_CYCLES = 16,
  parameter int CW            = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_access,
  input  logic [TW-1:0] cfg_hold,
  input  logic          cfg_ready_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_oe_n,
  output logic          mem_re_n,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_data,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [DW-1:0] snk_data,
  output logic          busy
);
  localparam int GR   = (GAP_CYCLES > RELOAD_CYCLES) ? GAP_CYCLES : RELOAD_CYCLES;
  localparam int TMAX = (GR > (1 << TW)) ? GR : (1 << TW);
  localparam int TMW  = $clog2(TMAX + 1);

  rd_state_e  st, nxt;
  rd_timing_t tcfg;
  logic           t_load, t_zero;
  logic [TMW-1:0] t_val;
  logic           trk_start, trk_step, trk_bclr;
  logic           none_left, burst_full;
  logic           sink_load;

  function automatic logic [TMW-1:0] phase_len(input logic [TW-1:0] v);
    return (v == '0) ? '0 : TMW'(v - 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      tcfg <= '0;
    end else begin
      st <= nxt;
      if (trk_start) tcfg <= '{setup: cfg_setup, access: cfg_access,
                               hold: cfg_hold, ready_en: cfg_ready_en};
    end
  end

  always_comb begin
    nxt       = st;
    t_load    = 1'b0;
    t_val     = '0;
    trk_start = 1'b0;
    trk_step  = 1'b0;
    trk_bclr  = 1'b0;
    sink_load = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid && (req_count != '0)) begin
          nxt       = ST_SETUP;
          t_load    = 1'b1;
          t_val     = phase_len(cfg_setup);
          trk_start = 1'b1;
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          nxt    = ST_ACCESS;
          t_load = 1'b1;
          t_val  = phase_len(tcfg.access);
        end
      end
      ST_ACCESS: begin
        if (t_zero && (!tcfg.ready_en || mem_ready)) nxt = ST_CAPT;
      end
      ST_CAPT: begin
        sink_load = 1'b1;
        trk_step  = 1'b1;
        nxt       = ST_HOLD;
        t_load    = 1'b1;
        t_val     = phase_len(tcfg.hold);
      end
      ST_HOLD: begin
        if (t_zero && !(snk_valid && !snk_ready)) begin
          t_load = 1'b1;
          if (none_left) begin
            nxt   = ST_RELOAD;
            t_val = TMW'(RELOAD_CYCLES - 1);
          end else if (burst_full) begin
            nxt      = ST_GAP;
            t_val    = TMW'(GAP_CYCLES - 1);
            trk_bclr = 1'b1;
          end else begin
            nxt   = ST_SETUP;
            t_val = phase_len(tcfg.setup);
          end
        end
      end
      ST_GAP: begin
        if (t_zero) begin
          nxt    = ST_SETUP;
          t_load = 1'b1;
          t_val  = phase_len(tcfg.setup);
        end
      end
      ST_RELOAD: begin
        if (t_zero) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  amrm_phase_timer #(.W(TMW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  amrm_word_tracker #(
    .AW(AW), .MAX_WORDS(MAX_WORDS), .BURST_LEN(BURST_LEN), .CW(CW)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (trk_start),
    .base       (req_addr),
    .count      (req_count),
    .step       (trk_step),
    .burst_clr  (trk_bclr),
    .addr       (mem_addr),
    .none_left  (none_left),
    .burst_full (burst_full)
  );

  amrm_sink_reg #(.DW(DW)) u_sink (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sink_load),
    .din       (mem_data),
    .snk_valid (snk_valid),
    .snk_ready (snk_ready),
    .snk_data  (snk_data)
  );

  assign mem_sel_n = !((st == ST_ACCESS) || (st == ST_CAPT));
  assign mem_oe_n  = !((st == ST_ACCESS) || (st == ST_CAPT));
  assign mem_re_n  = !(st == ST_ACCESS);
  assign req_ready = (st == ST_IDLE);
  assign busy      = (st != ST_IDLE) && (st != ST_RELOAD);

  AST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_re_n) |-> ($fell(mem_sel_n) && $fell(mem_oe_n))); // R2
  AST_RE_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_re_n) && tcfg.ready_en) |-> $past(mem_ready)); // R4
  AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re_n) |-> !mem_oe_n); // R3
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_sel_n && mem_oe_n && mem_re_n)); // R9
endmodule

// File: tb/test_amem_read_master.sv
`timescale 1ns/1ps
module test_amem_read_master;
  localparam int AW = 32, DW = 32, MAXW = 40, GAP = 9, RL = 5;
  localparam int CW = $clog2(MAXW + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [3:0] cfg_setup = 1, cfg_access = 1, cfg_hold = 1;
  logic cfg_ready_en = 0;
  logic [AW-1:0] mem_addr;
  logic mem_sel_n, mem_oe_n, mem_re_n;
  logic mem_ready = 1;
  logic [DW-1:0] mem_data;
  logic snk_valid, snk_ready = 1;
  logic [DW-1:0] snk_data;
  logic busy;

  int tests = 0, fails = 0;
  int rdy_rand = 0, snk_rand = 0;
  int rx_count = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit chk_en = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
  endfunction
  assign mem_data = data_of(mem_addr);

  amem_read_master #(.AW(AW), .DW(DW), .MAX_WORDS(MAXW), .BURST_LEN(8),
    .GAP_CYCLES(GAP), .RELOAD_CYCLES(RL)) i_amem_read_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .cfg_setup(cfg_setup),
    .cfg_access(cfg_access), .cfg_hold(cfg_hold), .cfg_ready_en(cfg_ready_en),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_oe_n(mem_oe_n),
    .mem_re_n(mem_re_n), .mem_ready(mem_ready), .mem_data(mem_data),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .busy(busy));

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: 0 idle,1 setup,2 access,3 capture,4 hold,5 gap,6 reload
  int m_st = 0, m_c = 0, m_rem = 0, m_pos = 0;
  int m_cs = 1, m_ca = 1, m_ch = 1;
  bit m_ren = 0, m_sv = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_sd = '0;

  function automatic int atleast1(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    bit hs, cap;
    if (!rst_n) begin
      m_st = 0; m_c = 0; m_sv = 0; m_pos = 0; m_rem = 0;
    end else begin
      hs = m_sv && snk_ready;
      if (snk_valid && snk_ready) rx_count++;
      cap = 0;
      case (m_st)
        0: if (req_valid && req_count != 0) begin
             m_rem = (int'(req_count) > MAXW) ? MAXW : int'(req_count);
             m_addr = req_addr; m_pos = 0;
             m_cs = atleast1(cfg_setup); m_ca = atleast1(cfg_access);
             m_ch = atleast1(cfg_hold); m_ren = cfg_ready_en;
             m_st = 1; m_c = m_cs - 1;
           end
        1: if (m_c == 0) begin m_st = 2; m_c = m_ca - 1; end else m_c--;
        2: if (m_c > 0) m_c--; else if (!m_ren || mem_ready) m_st = 3;
        3: begin
             cap = 1; m_sd = data_of(m_addr);
             m_addr++; m_rem--; m_pos++;
             m_st = 4; m_c = m_ch - 1;
           end
        4: if (m_c > 0) m_c--;
           else if (!(m_sv && !snk_ready)) begin
             if (m_rem == 0) begin m_st = 6; m_c = RL - 1; end
             else if (m_pos == 8) begin m_st = 5; m_c = GAP - 1; m_pos = 0; end
             else begin m_st = 1; m_c = m_cs - 1; end
           end
        5: if (m_c == 0) begin m_st = 1; m_c = m_cs - 1; end else m_c--;
        6: if (m_c == 0) m_st = 0; else m_c--;
        default: m_st = 0;
      endcase
      if (cap) m_sv = 1; else if (hs) m_sv = 0;
    end
  end

  always @(negedge clk) begin
    string tg;
    bit act_on, re_on;
    if (rst_n && chk_en) begin
      case (m_st)
        0: tg = "R1"; 1: tg = "R2"; 2: tg = m_ren ? "R4" : "R3";
        3: tg = "R3"; 4: tg = "R5"; 5: tg = "R6"; default: tg = "R7";
      endcase
      act_on = (m_st == 2) || (m_st == 3);
      re_on  = (m_st == 2);
      check(tg, "mem_sel_n", 64'(mem_sel_n), 64'(!act_on));
      check(tg, "mem_oe_n",  64'(mem_oe_n),  64'(!act_on));
      check(tg, "mem_re_n",  64'(mem_re_n),  64'(!re_on));
      check("R9", "busy", 64'(busy), 64'(m_st >= 1 && m_st <= 5));
      check("R7", "req_ready", 64'(req_ready), 64'(m_st == 0));
      check("R8", "snk_valid", 64'(snk_valid), 64'(m_sv));
      if (m_sv) check("R12", "snk_data", 64'(snk_data), 64'(m_sd));
      if (m_st >= 1 && m_st <= 3) check("R12", "mem_addr", 64'(mem_addr), 64'(m_addr));
    end
  end

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = rdy_rand ? (lfsr[3] & lfsr[7]) : 1'b1;
    snk_ready = snk_rand ? lfsr[5] : 1'b1;
  end

  task automatic send(input logic [AW-1:0] a, input int n);
    @(posedge clk); #2;
    req_addr = a; req_count = CW'(n); req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (m_st != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "sel", 64'(mem_sel_n), 64'd1);
    check("R1", "re", 64'(mem_re_n), 64'd1);
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "snk_valid", 64'(snk_valid), 64'd0);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    rst_n = 1;
    chk_en = 1;

    // R2 R3 R5: short transfer, fixed timing
    cfg_setup = 1; cfg_access = 2; cfg_hold = 1; cfg_ready_en = 0;
    rx_count = 0;
    send(32'h100, 3);
    wait_done();
    check("R12", "words received", 64'(rx_count), 64'd3);

    // R4 R6 R8: 32 words, ready extension, random back-pressure
    cfg_setup = 2; cfg_access = 3; cfg_hold = 2; cfg_ready_en = 1;
    rdy_rand = 1; snk_rand = 1; rx_count = 0;
    send(32'h2000, 32);
    wait_done();
    check("R6", "words received", 64'(rx_count), 64'd32);

    // R10: zero count
    send(32'h3000, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R10", "busy", 64'(busy), 64'd0);
      check("R10", "sel", 64'(mem_sel_n), 64'd1);
      check("R10", "req_ready", 64'(req_ready), 64'd1);
    end

    // R11 R2 R5: over-limit count, zero timing values
    cfg_setup = 0; cfg_access = 0; cfg_hold = 0; cfg_ready_en = 0;
    rdy_rand = 0; snk_rand = 1; rx_count = 0;
    send(32'hFFF0, 50);
    wait_done();
    check("R11", "words received", 64'(rx_count), 64'(MAXW));

    // R4: stretched access with a sparse ready line
    cfg_setup = 1; cfg_access = 1; cfg_hold = 3; cfg_ready_en = 1;
    rdy_rand = 1; snk_rand = 0; rx_count = 0;
    send(32'h40, 9);
    wait_done();
    check("R4", "words received", 64'(rx_count), 64'd9);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule